// File: doc/BRIEF.md
# Receive Clock Gating Sequencer

This block sits beside a serial receiver and decides, one serial clock period at a time, whether the receiver's clock runs and whether its carrier-detect input is asserted. A request carries a frame length in bits and a mode: framed-by-sync, where carrier-detect is a one-period marker in front of the frame, or level carrier-detect, where the line stays high across the frame. After accepting a request, the block leads in with one marked period, runs the clock for the frame, and then adds the extra trailing clocks that the chosen mode needs. These extra clocks push the receiver's last word out of its shift path before the clock is stopped.

Serial periods are marked by a one-cycle `bit_tick` pulse on the system clock. All state and all gating outputs move only on those pulses. In sync mode, the block also raises a strobe over the post-frame window in which a resynchronise (hunt) command may be issued. A guard gap follows, so the next sync marker cannot come too soon after the window. A request whose length cannot be handled is refused with a one-cycle error pulse.

Top module: `rx_clkgate_seq`

## Requirements
- R1: While reset is low, and after it is released with no request, `rx_clk_en`, `carrier_det`, `hunt_win`, `busy` and `len_err` are all 0.
- R2: A request is taken only at a `bit_tick` while idle with a valid length. The serial period that begins then is a lead-in period: `rx_clk_en`=1, `carrier_det`=1 and `busy`=1.
- R3: The next `frame_bits` periods carry the frame with `rx_clk_en`=1. `carrier_det` is 1 in level mode (`sync_mode`=0) and 0 in sync mode (`sync_mode`=1).
- R4: In level mode, post-frame periods 1 to 6 keep `carrier_det`=1 and `rx_clk_en`=1.
- R5: In level mode, post-frame periods 7 to 9 have `carrier_det`=0 with `rx_clk_en`=1. Period 10 has the clock stopped while still busy. The block is idle from period 11.
- R6: In sync mode, post-frame periods 1 to 9 have `rx_clk_en`=1. Periods 10 to 19 have it 0 while busy. The block is idle from period 20.
- R7: `hunt_win` is 1 only in sync mode, for post-frame periods 9 to 16 inclusive. At least three busy periods without the strobe follow it before a new request can be taken.
- R8: A request at a tick while idle is refused if `frame_bits` is 0, or if sync mode is selected and `frame_bits` bits [3:0] are not all 0 (not a multiple of 16). Refusal raises `len_err` for exactly one clock cycle, and the block stays idle.
- R9: Requests while busy are ignored and raise no `len_err`. Length and mode are held from the accepting tick, so later input changes do not alter the running sequence.
- R10: `rx_clk_en`, `carrier_det` and `hunt_win` are registers that change only on the clock edge that samples `bit_tick`=1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bit_tick | input | 1 | One-cycle pulse marking the start of each serial period |
| start_req | input | 1 | Frame request, sampled at a tick while idle |
| frame_bits | input | LEN_W | Frame length in serial bits |
| sync_mode | input | 1 | 1 = sync-marker mode, 0 = level carrier-detect mode |
| rx_clk_en | output | 1 | Receiver clock enable for the current serial period |
| carrier_det | output | 1 | Carrier-detect drive to the receiver |
| hunt_win | output | 1 | Window in which a hunt command may be issued |
| busy | output | 1 | A sequence is in progress |
| len_err | output | 1 | One-cycle pulse on a refused request |

## Verification
Every gating output is due on the clock edge that samples the tick, so each result belongs to the serial period that the tick opens. The bench drives a tick and samples at the following falling edge, where it compares against a per-period table computed from the frame length and mode. It then samples at the remaining falling edges of that period to confirm that the outputs did not move between ticks. `len_err` is due on the same edge as a refused tick and must be gone one cycle later; both of those edges are sampled.

// File: rtl/rcg_pkg.sv
package rcg_pkg;

   typedef enum logic [2:0] {
      ST_IDLE  = 3'd0,
      ST_PRE   = 3'd1,
      ST_FRAME = 3'd2,
      ST_HOLD  = 3'd3,
      ST_TAIL  = 3'd4,
      ST_STOP  = 3'd5
   } rcg_state_t;

endpackage

// File: rtl/rcg_len_check.sv
module rcg_len_check #(
   parameter int LEN_W     = 12,
   parameter int WORD_BITS = 16
) (
   input  logic [LEN_W-1:0] frame_bits,
   input  logic             sync_mode,
   output logic             len_bad
);

   localparam bit POW2 = ((WORD_BITS & (WORD_BITS - 1)) == 0);

   logic misalign;

   generate
      if (POW2) begin : g_mask
         localparam logic [LEN_W-1:0] LOW_MASK = LEN_W'(WORD_BITS - 1);
         assign misalign = |(frame_bits & LOW_MASK);
      end else begin : g_mod
         assign misalign = (frame_bits % LEN_W'(WORD_BITS)) != '0;
      end
   endgenerate

   // zero-length frames are never valid; word alignment only matters with sync markers
   assign len_bad = (frame_bits == '0) || (sync_mode && misalign);

endmodule

// File: rtl/rcg_counter.sv
module rcg_counter #(
   parameter int W = 8
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         load,
   input  logic [W-1:0] load_val,
   input  logic         step,
   output logic         at_zero
);

   logic [W-1:0] cnt_q;

   generate
      if (W < 1) begin : g_bad_w
         $error("rcg_counter: W must be at least 1");
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      cnt_q <= '0;
      else if (load)   cnt_q <= load_val;
      else if (step)   cnt_q <= cnt_q - W'(1);
   end

   assign at_zero = (cnt_q == '0);

   // R3: the phase count never wraps below zero
   p_no_underflow_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (step && !load) |-> !at_zero);

endmodule

// File: rtl/rcg_phase_fsm.sv
module rcg_phase_fsm
   import rcg_pkg::*;
#(
   parameter int LEN_W      = 12,
   parameter int HOLD_CLKS  = 6,
   parameter int NRM_TAIL   = 3,
   parameter int NRM_STOP   = 1,
   parameter int SYNC_TAIL  = 9,
   parameter int HUNT_FIRST = 9,
   parameter int HUNT_LAST  = 16,
   parameter int HUNT_GUARD = 3
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             tick,
   input  logic             start_req,
   input  logic             len_bad,
   input  logic [LEN_W-1:0] frame_bits,
   input  logic             sync_mode,
   output logic             clk_en,
   output logic             cd,
   output logic             hunt,
   output logic             busy,
   output logic             len_err
);

   localparam int SYNC_STOP = HUNT_LAST - SYNC_TAIL + HUNT_GUARD;
   localparam int NRM_POST  = HOLD_CLKS + NRM_TAIL + NRM_STOP;
   localparam int SYN_POST  = SYNC_TAIL + SYNC_STOP;
   localparam int PMAX      = (NRM_POST > SYN_POST) ? NRM_POST : SYN_POST;
   localparam int PW        = $clog2(PMAX + 2);
   localparam int TM1       = (HOLD_CLKS > NRM_TAIL) ? HOLD_CLKS : NRM_TAIL;
   localparam int TM2       = (SYNC_TAIL > SYNC_STOP) ? SYNC_TAIL : SYNC_STOP;
   localparam int TM3       = (TM1 > TM2) ? TM1 : TM2;
   localparam int TMAX      = (TM3 > NRM_STOP) ? TM3 : NRM_STOP;
   localparam int TW        = $clog2(TMAX + 1);
   localparam int CW        = (LEN_W > TW) ? LEN_W : TW;

   rcg_state_t       st_q, st_d;
   logic             mode_q;
   logic [LEN_W-1:0] len_q;
   logic [PW-1:0]    post_q, post_d;
   logic             ph_load, ph_step, ph_zero;
   logic [CW-1:0]    ph_val;
   logic             accept;
   logic             en_d, cd_d, hunt_d;
   logic             en_q, cd_q, hunt_q, err_q;

   rcg_counter #(.W(CW)) u_phase (
      .clk      (clk),
      .rst_n    (rst_n),
      .load     (ph_load),
      .load_val (ph_val),
      .step     (ph_step),
      .at_zero  (ph_zero)
   );

   assign accept = tick && (st_q == ST_IDLE) && start_req && !len_bad;

   always_comb begin
      st_d    = st_q;
      post_d  = post_q;
      ph_load = 1'b0;
      ph_step = 1'b0;
      ph_val  = '0;
      if (tick) begin
         unique case (st_q)
            ST_IDLE: begin
               if (start_req && !len_bad) begin
                  st_d    = ST_PRE;
                  ph_load = 1'b1;
               end
            end
            ST_PRE: begin
               st_d    = ST_FRAME;
               ph_load = 1'b1;
               ph_val  = CW'(len_q) - CW'(1);
            end
            ST_FRAME: begin
               if (ph_zero) begin
                  post_d  = PW'(1);
                  ph_load = 1'b1;
                  if (mode_q) begin
                     st_d   = ST_TAIL;
                     ph_val = CW'(SYNC_TAIL - 1);
                  end else begin
                     st_d   = ST_HOLD;
                     ph_val = CW'(HOLD_CLKS - 1);
                  end
               end else begin
                  ph_step = 1'b1;
               end
            end
            ST_HOLD: begin
               post_d = post_q + PW'(1);
               if (ph_zero) begin
                  st_d    = ST_TAIL;
                  ph_load = 1'b1;
                  ph_val  = CW'(NRM_TAIL - 1);
               end else begin
                  ph_step = 1'b1;
               end
            end
            ST_TAIL: begin
               post_d = post_q + PW'(1);
               if (ph_zero) begin
                  st_d    = ST_STOP;
                  ph_load = 1'b1;
                  ph_val  = mode_q ? CW'(SYNC_STOP - 1) : CW'(NRM_STOP - 1);
               end else begin
                  ph_step = 1'b1;
               end
            end
            ST_STOP: begin
               if (ph_zero) begin
                  st_d = ST_IDLE;
               end else begin
                  post_d  = post_q + PW'(1);
                  ph_step = 1'b1;
               end
            end
            default: st_d = ST_IDLE;
         endcase
      end
   end

   // decode of the period that the current tick opens
   always_comb begin
      en_d   = (st_d == ST_PRE) || (st_d == ST_FRAME) ||
               (st_d == ST_HOLD) || (st_d == ST_TAIL);
      cd_d   = (st_d == ST_PRE) ||
               (!mode_q && ((st_d == ST_FRAME) || (st_d == ST_HOLD)));
      hunt_d = mode_q && ((st_d == ST_TAIL) || (st_d == ST_STOP)) &&
               (post_d >= PW'(HUNT_FIRST)) && (post_d <= PW'(HUNT_LAST));
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_q   <= ST_IDLE;
         post_q <= '0;
         mode_q <= 1'b0;
         len_q  <= '0;
         en_q   <= 1'b0;
         cd_q   <= 1'b0;
         hunt_q <= 1'b0;
         err_q  <= 1'b0;
      end else begin
         st_q   <= st_d;
         post_q <= post_d;
         err_q  <= tick && (st_q == ST_IDLE) && start_req && len_bad;
         if (accept) begin
            mode_q <= sync_mode;
            len_q  <= frame_bits;
         end
         if (tick) begin
            en_q   <= en_d;
            cd_q   <= cd_d;
            hunt_q <= hunt_d;
         end
      end
   end

   assign clk_en  = en_q;
   assign cd      = cd_q;
   assign hunt    = hunt_q;
   assign busy    = (st_q != ST_IDLE);
   assign len_err = err_q;

   // R10: gating outputs hold still between serial periods
   p_tick_only_r10: assert property (@(posedge clk) disable iff (!rst_n)
      !tick |=> ($stable(en_q) && $stable(cd_q) && $stable(hunt_q)));

   // R3: carrier-detect is never driven without a running clock
   p_cd_with_clk_r3: assert property (@(posedge clk) disable iff (!rst_n)
      cd_q |-> en_q);

   // R5: in level mode the clock keeps running after carrier-detect drops
   p_cd_release_r5: assert property (@(posedge clk) disable iff (!rst_n)
      ($fell(cd_q) && !mode_q) |-> en_q);

   // R7: hunt strobe only in sync mode and never alongside carrier-detect
   p_hunt_sync_r7: assert property (@(posedge clk) disable iff (!rst_n)
      hunt_q |-> (mode_q && !cd_q && busy));

   // R8: a refusal leaves the sequencer idle
   p_reject_idle_r8: assert property (@(posedge clk) disable iff (!rst_n)
      err_q |-> (st_q == ST_IDLE));

   // R9: the latched mode is untouched while a sequence runs
   p_mode_held_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (st_q != ST_IDLE) |=> $stable(mode_q));

endmodule

// File: rtl/rx_clkgate_seq.sv
module rx_clkgate_seq #(
   parameter int LEN_W      = 12,
   parameter int WORD_BITS  = 16,
   parameter int HOLD_CLKS  = 6,
   parameter int NRM_TAIL   = 3,
   parameter int NRM_STOP   = 1,
   parameter int SYNC_TAIL  = 9,
   parameter int HUNT_FIRST = 9,
   parameter int HUNT_LAST  = 16,
   parameter int HUNT_GUARD = 3
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             bit_tick,
   input  logic             start_req,
   input  logic [LEN_W-1:0] frame_bits,
   input  logic             sync_mode,
   output logic             rx_clk_en,
   output logic             carrier_det,
   output logic             hunt_win,
   output logic             busy,
   output logic             len_err
);

   generate
      if (LEN_W < 2 || LEN_W > 30) begin : g_bad_len_w
         $error("rx_clkgate_seq: LEN_W out of range");
      end
      if (WORD_BITS < 1 || WORD_BITS >= (1 << LEN_W)) begin : g_bad_word
         $error("rx_clkgate_seq: WORD_BITS must fit below 2**LEN_W");
      end
      if (HOLD_CLKS < 1 || NRM_TAIL < 1 || NRM_STOP < 1 || SYNC_TAIL < 1) begin : g_bad_tail
         $error("rx_clkgate_seq: trailing counts must be at least 1");
      end
      if (HUNT_FIRST < 1 || HUNT_FIRST > HUNT_LAST || HUNT_LAST < SYNC_TAIL) begin : g_bad_hunt
         $error("rx_clkgate_seq: hunt window must sit inside the post-frame span");
      end
      if (HUNT_GUARD < 1) begin : g_bad_guard
         $error("rx_clkgate_seq: HUNT_GUARD must be at least 1");
      end
   endgenerate

   logic len_bad;

   rcg_len_check #(
      .LEN_W     (LEN_W),
      .WORD_BITS (WORD_BITS)
   ) u_len (
      .frame_bits (frame_bits),
      .sync_mode  (sync_mode),
      .len_bad    (len_bad)
   );

   rcg_phase_fsm #(
      .LEN_W      (LEN_W),
      .HOLD_CLKS  (HOLD_CLKS),
      .NRM_TAIL   (NRM_TAIL),
      .NRM_STOP   (NRM_STOP),
      .SYNC_TAIL  (SYNC_TAIL),
      .HUNT_FIRST (HUNT_FIRST),
      .HUNT_LAST  (HUNT_LAST),
      .HUNT_GUARD (HUNT_GUARD)
   ) u_fsm (
      .clk        (clk),
      .rst_n      (rst_n),
      .tick       (bit_tick),
      .start_req  (start_req),
      .len_bad    (len_bad),
      .frame_bits (frame_bits),
      .sync_mode  (sync_mode),
      .clk_en     (rx_clk_en),
      .cd         (carrier_det),
      .hunt       (hunt_win),
      .busy       (busy),
      .len_err    (len_err)
   );

endmodule

// File: tb/rx_clkgate_seq_tb.sv
module rx_clkgate_seq_tb;

   localparam int LW = 6;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          bit_tick = 1'b0;
   logic          start_req = 1'b0;
   logic          sync_mode = 1'b0;
   logic [LW-1:0] frame_bits = '0;
   logic          rx_clk_en, carrier_det, hunt_win, busy, len_err;

   int checks = 0;
   int fails = 0;
   bit done = 1'b0;

   always #5 clk = ~clk;

   rx_clkgate_seq #(.LEN_W(LW)) u_dut (
      .clk         (clk),
      .rst_n       (rst_n),
      .bit_tick    (bit_tick),
      .start_req   (start_req),
      .frame_bits  (frame_bits),
      .sync_mode   (sync_mode),
      .rx_clk_en   (rx_clk_en),
      .carrier_det (carrier_det),
      .hunt_win    (hunt_win),
      .busy        (busy),
      .len_err     (len_err)
   );

   task automatic chk(input string req, input string what, input int act, input int exp);
      checks++;
      if (act != exp) begin
         fails++;
         $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
      end
   endtask

   // opens one serial period; returns at the falling edge after the tick edge
   task automatic step();
      @(negedge clk) bit_tick = 1'b1;
      @(negedge clk) bit_tick = 1'b0;
   endtask

   // R10: the rest of the period must show no change; len_err pulse gone (R8)
   task automatic hold_rest();
      int snap;
      snap = {rx_clk_en, carrier_det, hunt_win, busy};
      for (int k = 0; k < 2; k++) begin
         @(negedge clk);
         chk("R10", "outputs between ticks", {rx_clk_en, carrier_det, hunt_win, busy}, snap);
         chk("R8", "len_err one cycle only", len_err, 0);
      end
   endtask

   // expected outputs for serial period p after acceptance
   task automatic expect_at(input int n, input bit m, input int p,
                            output int en, output int cd, output int hu,
                            output int bz, output string tag);
      int q;
      q = p - n;
      en = 0; cd = 0; hu = 0; bz = 0;
      if (p == 0) begin
         en = 1; cd = 1; bz = 1; tag = "R2";
      end else if (q <= 0) begin
         en = 1; cd = m ? 0 : 1; bz = 1; tag = "R3";
      end else if (!m) begin
         if (q <= 6)       begin en = 1; cd = 1; bz = 1; tag = "R4"; end
         else if (q <= 9)  begin en = 1; bz = 1; tag = "R5"; end
         else if (q == 10) begin bz = 1; tag = "R5"; end
         else              tag = "R5";
      end else begin
         if (q <= 9)       begin en = 1; bz = 1; tag = "R6"; end
         else if (q <= 19) begin bz = 1; tag = "R6"; end
         else              tag = "R6";
         if (q >= 9 && q <= 16) hu = 1;
      end
   endtask

   task automatic run_frame(input int n, input bit m);
      int last, en, cd, hu, bz;
      string tag;
      bit bad;
      bad = (n == 0) || (m && (n % 16) != 0);
      frame_bits = LW'(n);
      sync_mode  = m;
      start_req  = 1'b1;
      step();
      start_req = 1'b0;
      if (bad) begin
         chk("R8", "len_err on refusal", len_err, 1);
         chk("R8", "busy after refusal", busy, 0);
         chk("R8", "clk_en after refusal", rx_clk_en, 0);
         hold_rest();
         return;
      end
      last = n + (m ? 20 : 11);
      for (int p = 0; p <= last; p++) begin
         if (p > 0) begin
            if (p == 1) begin
               // R9: conflicting request while busy
               start_req  = 1'b1;
               sync_mode  = ~m;
               frame_bits = LW'(n + 5);
            end
            step();
            start_req = 1'b0;
         end
         expect_at(n, m, p, en, cd, hu, bz, tag);
         chk(tag, "rx_clk_en", rx_clk_en, en);
         chk(tag, "carrier_det", carrier_det, cd);
         chk("R7", "hunt_win", hunt_win, hu);
         chk(tag, "busy", busy, bz);
         chk("R9", "no len_err while running", len_err, 0);
         hold_rest();
      end
   endtask

   initial begin
      repeat (3) @(negedge clk);
      chk("R1", "clk_en in reset", rx_clk_en, 0);
      chk("R1", "cd in reset", carrier_det, 0);
      chk("R1", "busy in reset", busy, 0);
      rst_n = 1'b1;
      for (int k = 0; k < 3; k++) begin
         step();
         chk("R1", "idle outputs", {rx_clk_en, carrier_det, hunt_win, busy, len_err}, 0);
      end
      for (int m = 0; m < 2; m++) begin
         for (int n = 0; n < (1 << LW); n++) begin
            run_frame(n, m[0]);
         end
      end
      // back-to-back sync frames to confirm the guard gap still allows restart
      run_frame(16, 1'b1);
      run_frame(32, 1'b1);
      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         fails++;
         $display("FAIL watchdog expired actual=%0d expected=%0d", 0, 1);
         $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
         $finish;
      end
   end

endmodule